// File: doc/BRIEF.md
# Redundant-Binary to Two's-Complement Converter

This block turns a signed-digit number, in which every digit is one of −1, 0 or +1, into an ordinary two's-complement word of the same width. Each digit comes in as a pair of bits, one in a "positive" vector and one in a "negative" vector. The digit's value is the positive bit minus the negative bit. The whole number is therefore the positive vector minus the negative vector. This is the one step that has to propagate carries after a carry-free accumulation tree, so it usually sits at the very end of a multiplier datapath.

The subtraction is computed as positive + (inverted negative) + 1. The +1 enters as the carry into the lowest group. The datapath is cut into four-bit carry-lookahead groups. Each group reports a group-generate and a group-propagate term. A parallel-prefix network turns these terms into the carry entering every group. No group waits on another group's sum bits. The final carry out of the top group is dropped. A parameter selects whether the result passes through one output register or leaves combinationally.

Top module: `rb2nb_conv`

## Requirements
- R1: `nb_word` equals (`dig_pos` − `dig_neg`) modulo 2^DIGITS, where bit i of each input vector holds the positive and negative half of digit i (digit value = pos bit − neg bit).
- R2: A digit encoded as (0,0) and a digit encoded as (1,1) both count as zero; when the two input vectors are identical, the result is all zeros.
- R3: With `dig_neg` all zero, the result equals `dig_pos` unchanged.
- R4: With `dig_pos` all zero, the result is the two's-complement negation of `dig_neg`.
- R5: The carry out of the most significant group is discarded, so results wrap modulo 2^DIGITS (for example, positive 0 and negative all-ones give 1).
- R6: With OUT_REG=1, the result appears on the first rising clock edge after the inputs are applied and holds until the next edge. With OUT_REG=0, the result follows the inputs within the same cycle.
- R7: With OUT_REG=1, a synchronous active-high `rst` sampled at a clock edge forces `nb_word` to zero at that edge, whatever the inputs are.
- R8: The lookahead network delivers to every group boundary the same carry that a ripple of the group below would produce. This includes borrow chains that cross every group.
- R9: DIGITS need not be a multiple of four. The top group is padded and the result is still exact over DIGITS bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| dig_pos | input | DIGITS | Positive half of each signed digit |
| dig_neg | input | DIGITS | Negative half of each signed digit |
| nb_word | output | DIGITS | Two's-complement result |

## Verification
The bench builds three copies. The first has DIGITS=8 and a registered output. It is swept over all 65,536 pairs of positive and negative vectors, so every digit pattern and every carry path across two groups is covered, along with the one-cycle latency. The second has DIGITS=6 and a combinational output. It exercises the padded top group over its full 4,096-pair space. The third is the 32-digit default. Directed patterns drive borrow chains across all eight group boundaries and the wrap cases, and random vectors follow.

// File: rtl/rb2nb_pkg.sv
package rb2nb_pkg;
  localparam int GRP_W = 4;

  function automatic int grp_count(input int digits);
    return (digits + GRP_W - 1) / GRP_W;
  endfunction

  function automatic int prefix_levels(input int nodes);
    return (nodes > 1) ? $clog2(nodes) : 1;
  endfunction
endpackage

// File: rtl/rb2nb_prep.sv
module rb2nb_prep #(
  parameter int DIGITS = 32,
  parameter int PADW   = 32
) (
  input  logic [DIGITS-1:0] dig_pos,
  input  logic [DIGITS-1:0] dig_neg,
  output logic [PADW-1:0]   add_a,
  output logic [PADW-1:0]   add_b
);
  // Subtraction as addition: a + ~b, the +1 enters at the lowest carry.
  generate
    if (PADW > DIGITS) begin : g_pad
      assign add_a = {{(PADW-DIGITS){1'b0}}, dig_pos};
      assign add_b = ~{{(PADW-DIGITS){1'b0}}, dig_neg};
    end else begin : g_nopad
      assign add_a = dig_pos;
      assign add_b = ~dig_neg;
    end
  endgenerate
endmodule

// File: rtl/rb2nb_cla4.sv
module rb2nb_cla4 (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       grp_g,
  output logic       grp_p,
  output logic       cout
);
  logic [3:0] gen, prp;
  logic       c1, c2, c3;

  assign gen = a & b;
  assign prp = a ^ b;

  assign c1 = gen[0] | (prp[0] & cin);
  assign c2 = gen[1] | (prp[1] & gen[0]) | (prp[1] & prp[0] & cin);
  assign c3 = gen[2] | (prp[2] & gen[1]) | (prp[2] & prp[1] & gen[0])
            | (prp[2] & prp[1] & prp[0] & cin);

  assign grp_g = gen[3] | (prp[3] & gen[2]) | (prp[3] & prp[2] & gen[1])
               | (prp[3] & prp[2] & prp[1] & gen[0]);
  assign grp_p = &prp;

  // Local carry out, only used to cross-check the lookahead network.
  assign cout = grp_g | (grp_p & cin);

  assign sum = prp ^ {c3, c2, c1, cin};
endmodule

// File: rtl/rb2nb_lookahead.sv
module rb2nb_lookahead
  import rb2nb_pkg::*;
#(
  parameter int NGRP = 8
) (
  input  logic [NGRP-1:0] grp_g,
  input  logic [NGRP-1:0] grp_p,
  input  logic            cin,
  output logic [NGRP:0]   carry
);
  localparam int NN = NGRP + 1;
  localparam int LV = prefix_levels(NN);

  logic [NN-1:0] gv [LV+1];
  logic [NN-1:0] pv [LV+1];

  // Node 0 is the carry-in; node j+1 is group j. After the prefix,
  // node j holds the carry entering group j.
  always_comb begin
    gv[0][0] = cin;
    pv[0][0] = 1'b0;
    for (int j = 0; j < NGRP; j++) begin
      gv[0][j+1] = grp_g[j];
      pv[0][j+1] = grp_p[j];
    end
    for (int l = 0; l < LV; l++) begin
      for (int i = 0; i < NN; i++) begin
        if (i >= (1 << l)) begin
          gv[l+1][i] = gv[l][i] | (pv[l][i] & gv[l][i - (1 << l)]);
          pv[l+1][i] = pv[l][i] & pv[l][i - (1 << l)];
        end else begin
          gv[l+1][i] = gv[l][i];
          pv[l+1][i] = pv[l][i];
        end
      end
    end
  end

  assign carry = gv[LV];
endmodule

// File: rtl/rb2nb_conv.sv
module rb2nb_conv
  import rb2nb_pkg::*;
#(
  parameter int DIGITS  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIGITS-1:0] dig_pos,
  input  logic [DIGITS-1:0] dig_neg,
  output logic [DIGITS-1:0] nb_word
);
  localparam int NGRP = grp_count(DIGITS);
  localparam int PADW = NGRP * GRP_W;

  logic [PADW-1:0] add_a, add_b, sum_pad;
  logic [NGRP-1:0] grp_g, grp_p, grp_cout;
  logic [NGRP:0]   grp_carry;
  logic [DIGITS-1:0] nb_comb;

  rb2nb_prep #(.DIGITS(DIGITS), .PADW(PADW)) u_prep (
    .dig_pos (dig_pos),
    .dig_neg (dig_neg),
    .add_a   (add_a),
    .add_b   (add_b)
  );

  generate
    for (genvar j = 0; j < NGRP; j++) begin : g_grp
      rb2nb_cla4 u_cla (
        .a     (add_a[j*GRP_W +: GRP_W]),
        .b     (add_b[j*GRP_W +: GRP_W]),
        .cin   (grp_carry[j]),
        .sum   (sum_pad[j*GRP_W +: GRP_W]),
        .grp_g (grp_g[j]),
        .grp_p (grp_p[j]),
        .cout  (grp_cout[j])
      );
    end
  endgenerate

  rb2nb_lookahead #(.NGRP(NGRP)) u_net (
    .grp_g (grp_g),
    .grp_p (grp_p),
    .cin   (1'b1),
    .carry (grp_carry)
  );

  assign nb_comb = sum_pad[DIGITS-1:0];

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) nb_word <= '0;
        else     nb_word <= nb_comb;
      end
    end else begin : g_comb
      assign nb_word = nb_comb;
    end
  endgenerate
endmodule

// File: rtl/rb2nb_chk.sv
module rb2nb_chk #(
  parameter int DIGITS  = 32,
  parameter int NGRP    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [DIGITS-1:0] dig_pos,
  input logic [DIGITS-1:0] dig_neg,
  input logic [DIGITS-1:0] nb_word,
  input logic [NGRP:0]     grp_carry,
  input logic [NGRP-1:0]   grp_cout
);
  logic [DIGITS-1:0] diff_ref;
  assign diff_ref = dig_pos - dig_neg;

  // R8: lookahead carry into group j+1 matches group j's local carry out
  p_carry_match_r8: assert property (@(posedge clk) disable iff (rst)
    grp_carry[NGRP:1] == grp_cout);

  generate
    if (OUT_REG) begin : g_reg
      p_value_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> nb_word == $past(diff_ref));
      p_same_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (dig_pos == dig_neg) |=> nb_word == '0);
      p_plus_only_r3: assert property (@(posedge clk) disable iff (rst)
        (dig_neg == '0) |=> nb_word == $past(dig_pos));
      p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> nb_word == '0);
    end else begin : g_comb
      p_value_r1: assert property (@(posedge clk) disable iff (rst)
        nb_word == diff_ref);
      p_same_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (dig_pos == dig_neg) |-> nb_word == '0);
      p_plus_only_r3: assert property (@(posedge clk) disable iff (rst)
        (dig_neg == '0) |-> nb_word == dig_pos);
    end
  endgenerate
endmodule

bind rb2nb_conv rb2nb_chk #(.DIGITS(DIGITS), .NGRP(NGRP), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dig_pos   (dig_pos),
  .dig_neg   (dig_neg),
  .nb_word   (nb_word),
  .grp_carry (grp_carry),
  .grp_cout  (grp_cout)
);

// File: tb/sim_rb2nb_conv.sv
module sim_rb2nb_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]  p0 = '0, m0 = '0, q0;
  logic [5:0]  p1 = '0, m1 = '0, q1;
  logic [31:0] p2 = '0, m2 = '0, q2;

  int checks = 0;
  int fails  = 0;

  rb2nb_conv #(.DIGITS(8), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .dig_pos(p0), .dig_neg(m0), .nb_word(q0));
  rb2nb_conv #(.DIGITS(6), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst(rst), .dig_pos(p1), .dig_neg(m1), .nb_word(q1));
  rb2nb_conv #(.DIGITS(32), .OUT_REG(1'b1)) u2 (
    .clk(clk), .rst(rst), .dig_pos(p2), .dig_neg(m2), .nb_word(q2));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string cls8(input logic [7:0] p, input logic [7:0] m);
    if (p == m)       return "R2 identical vectors";
    else if (m == '0) return "R3 plus only";
    else if (p == '0) return "R4 minus only";
    else              return "R1 difference";
  endfunction

  task automatic drive32(input logic [31:0] p, input logic [31:0] m, input string tag);
    logic [31:0] e;
    @(negedge clk);
    p2 = p; m2 = m;
    e = p - m;
    @(posedge clk); #1;
    chk(tag, {32'd0, q2}, {32'd0, e});
  endtask

  initial begin
    logic [7:0] prev_exp;
    logic [7:0] e0;
    logic [5:0] e1;
    prev_exp = '0;

    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset value u0", {56'd0, q0}, 64'd0);
    chk("R7 reset value u2", {32'd0, q2}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // Full sweep of the 8-digit copy; the 6-digit copy follows the low bits.
    for (int pi = 0; pi < 256; pi++) begin
      for (int mi = 0; mi < 256; mi++) begin
        @(negedge clk);
        p0 = 8'(pi); m0 = 8'(mi);
        p1 = p0[5:0]; m1 = m0[5:0];
        e0 = p0 - m0;
        e1 = p1 - m1;
        #1;
        chk("R9 padded group comb", {58'd0, q1}, {58'd0, e1});
        chk("R6 holds before edge", {56'd0, q0}, {56'd0, prev_exp});
        @(posedge clk); #1;
        chk(cls8(p0, m0), {56'd0, q0}, {56'd0, e0});
        prev_exp = e0;
      end
    end

    // R7: reset mid-run with nonzero inputs
    @(negedge clk);
    p0 = 8'hFF; m0 = 8'h01; p2 = 32'h1234_5678; m2 = 32'h0000_0001;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R7 reset clears u0", {56'd0, q0}, 64'd0);
    chk("R7 reset clears u2", {32'd0, q2}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    drive32(32'h0000_0000, 32'hFFFF_FFFF, "R5 wrap to one");
    drive32(32'hFFFF_FFFF, 32'h0000_0000, "R3 all ones passthrough");
    drive32(32'h0000_0001, 32'h8000_0000, "R5 wrap high");
    drive32(32'h0000_0000, 32'h0000_0001, "R4 minus one");
    drive32(32'h8000_0000, 32'h0000_0001, "R8 borrow across all groups");
    drive32(32'h0001_0000, 32'h0000_0001, "R8 borrow across four groups");
    drive32(32'hA5A5_A5A5, 32'hA5A5_A5A5, "R2 identical wide");
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 all digits one-one");
    for (int k = 0; k < 400; k++) begin
      drive32($urandom, $urandom, "R1 random wide");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule